// File: doc/BRIEF.md
# Segmented Self-Triggered Sample Buffer

This block captures short bursts of a digitized input stream into a ring of fixed-length segments. A burst starts by itself when an incoming sample rises above a programmable threshold. From that sample on, the next 32 valid samples fill the current segment, together with a timestamp taken from a free-running cycle counter. When the segment is complete it is committed and becomes visible to the reader. Writing then moves to the next free segment.

Readout runs at the same time as capture. A reader port drains committed segments oldest first through a valid/ready handshake. Each segment comes out as one timestamp word followed by its 32 samples, and a flag tells the reader when data is waiting. The reader may discard the segment at the head without transferring it. When every segment holds unread data, new triggers are dropped and counted, so the link to the host can fall behind for a while without the ring being corrupted.

Top module: `seg_trig_buffer`

## Requirements
- R1: After reset, data_avail_o, rd_valid_o and rd_last_o are 0 and ovf_cnt_o is 0.
- R2: While idle, a valid sample strictly greater than threshold_i starts a capture. A valid sample equal to or below it does not, so no segment is ever committed from such samples.
- R3: A capture stores the trigger sample and the next 31 cycles with sample_valid_i high, in order. Cycles with sample_valid_i low are not stored.
- R4: A segment is read as 33 beats. Beat 0 carries the timestamp on rd_data_o[31:0]. Beats 1 to 32 carry samples 0 to 31 in bits [11:0] with the upper bits zero. rd_last_o is high only on beat 32.
- R5: The timestamp is the value of a 32-bit counter that is 0 in the first cycle after reset and counts up by one each clock, sampled in the cycle where the trigger sample is accepted.
- R6: During a capture, samples above the threshold do not start a new segment and do not change the latched timestamp.
- R7: Segments are read in the order they were committed. Capture and readout proceed at the same time without affecting each other.
- R8: data_avail_o (and rd_valid_o) is high exactly when at least one committed segment is unread. A segment still being filled does not raise it.
- R9: With rd_skip_i high while data is available, the head segment is discarded in that cycle. The next cycle presents beat 0 of the following segment.
- R10: Up to 128 committed segments are held. A trigger that arrives while all 128 are held is dropped and increments ovf_cnt_o, which saturates at 255.
- R11: While rd_valid_o is high and rd_ready_i and rd_skip_i are low, rd_data_o and rd_last_o hold their values and rd_valid_o stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_i | input | 12 | Incoming sample |
| sample_valid_i | input | 1 | sample_i carries a new sample |
| threshold_i | input | 12 | Trigger threshold; a capture starts on a sample greater than this |
| rd_data_o | output | 32 | Readout word: timestamp, then zero-extended samples |
| rd_valid_o | output | 1 | A readout word is presented |
| rd_ready_i | input | 1 | Reader accepts the presented word |
| rd_last_o | output | 1 | Presented word is the final sample of its segment |
| rd_skip_i | input | 1 | Discard the head segment |
| data_avail_o | output | 1 | At least one committed segment is waiting |
| ovf_cnt_o | output | 8 | Count of triggers dropped while full, saturating |

## Verification
The assertions assume that threshold_i stays constant while a capture runs, and that rd_skip_i is not raised together with rd_ready_i. The stimulus follows both rules: it changes the threshold only between tests and pulses skip only with ready held low. The embedded checks also assume that rd_skip_i is raised only while a segment is at the head. The bench sets the ring up so that this holds for every skip it issues. Triggers are raised only when the bench knows whether the ring has room, so each expected segment is queued exactly when it will be stored.

// File: rtl/segbuf_pkg.sv
package segbuf_pkg;
  localparam int unsigned SAMPLE_W_DEF = 12;
  localparam int unsigned SEG_LEN_DEF  = 32;
  localparam int unsigned NUM_SEG_DEF  = 128;
  localparam int unsigned TS_W_DEF     = 32;
  localparam int unsigned OVF_W_DEF    = 8;

  typedef enum logic {
    CAP_IDLE = 1'b0,
    CAP_FILL = 1'b1
  } cap_state_e;
endpackage

// File: rtl/segbuf_capture.sv
module segbuf_capture
  import segbuf_pkg::*;
#(
  parameter int unsigned SAMPLE_W = SAMPLE_W_DEF,
  parameter int unsigned SEG_LEN  = SEG_LEN_DEF,
  parameter int unsigned TS_W     = TS_W_DEF,
  parameter int unsigned OVF_W    = OVF_W_DEF,
  localparam int unsigned OFF_W   = $clog2(SEG_LEN)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic                sample_valid_i,
  input  logic [SAMPLE_W-1:0] threshold_i,
  input  logic                full_i,
  output logic                wr_en_o,
  output logic [OFF_W-1:0]    wr_off_o,
  output logic                commit_o,
  output logic                ts_we_o,
  output logic [TS_W-1:0]     ts_o,
  output logic [OVF_W-1:0]    ovf_cnt_o
);
  localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(SEG_LEN - 1);

  cap_state_e       state_q;
  logic [OFF_W-1:0] off_q;
  logic [TS_W-1:0]  ts_cnt_q;
  logic             trig, accept, drop;

  assign trig     = sample_valid_i && (state_q == CAP_IDLE) && (sample_i > threshold_i);
  assign accept   = trig && !full_i;
  assign drop     = trig && full_i;
  assign wr_en_o  = sample_valid_i && ((state_q == CAP_FILL) || accept);
  assign wr_off_o = (state_q == CAP_FILL) ? off_q : '0;
  assign commit_o = wr_en_o && (wr_off_o == LAST_OFF);
  assign ts_we_o  = accept;
  assign ts_o     = ts_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ts_cnt_q <= '0;
    end else begin
      ts_cnt_q <= ts_cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= CAP_IDLE;
      off_q   <= '0;
    end else if (state_q == CAP_IDLE) begin
      if (accept) begin
        state_q <= CAP_FILL;
        off_q   <= OFF_W'(1);
      end
    end else if (sample_valid_i) begin
      if (off_q == LAST_OFF) begin
        state_q <= CAP_IDLE;
        off_q   <= '0;
      end else begin
        off_q <= off_q + 1'b1;
      end
    end
  end

  // saturating drop counter
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_cnt_o <= '0;
    end else if (drop && (ovf_cnt_o != '1)) begin
      ovf_cnt_o <= ovf_cnt_o + 1'b1;
    end
  end

  assert_no_retrigger_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == CAP_FILL) |=> !ts_we_o || $past(commit_o));

  assert_ovf_saturates_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_cnt_o == '1) |=> (ovf_cnt_o == '1));

  assert_ovf_only_when_full_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_cnt_o != $past(ovf_cnt_o)) |-> $past(full_i));

  assert_commit_closes_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |=> (wr_off_o == '0));
endmodule

// File: rtl/segbuf_ring.sv
module segbuf_ring
  import segbuf_pkg::*;
#(
  parameter int unsigned NUM_SEG = NUM_SEG_DEF,
  localparam int unsigned SEG_W  = $clog2(NUM_SEG),
  localparam int unsigned PTR_W  = SEG_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             commit_i,
  input  logic             pop_i,
  output logic [SEG_W-1:0] wr_seg_o,
  output logic [SEG_W-1:0] rd_seg_o,
  output logic             empty_o,
  output logic             full_o
);
  // extra MSB separates full from empty
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;

  assign wr_seg_o = wr_ptr_q[SEG_W-1:0];
  assign rd_seg_o = rd_ptr_q[SEG_W-1:0];
  assign empty_o  = (wr_ptr_q == rd_ptr_q);
  assign full_o   = (wr_ptr_q[SEG_W-1:0] == rd_ptr_q[SEG_W-1:0]) &&
                    (wr_ptr_q[SEG_W] != rd_ptr_q[SEG_W]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else begin
      if (commit_i) wr_ptr_q <= wr_ptr_q + 1'b1;
      if (pop_i)    rd_ptr_q <= rd_ptr_q + 1'b1;
    end
  end

  assert_no_commit_when_full_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |-> !full_o);

  assert_no_pop_when_empty_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);

  assert_commit_makes_avail_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && !pop_i) |=> !empty_o);
endmodule

// File: rtl/segbuf_store.sv
module segbuf_store
  import segbuf_pkg::*;
#(
  parameter int unsigned SAMPLE_W = SAMPLE_W_DEF,
  parameter int unsigned SEG_LEN  = SEG_LEN_DEF,
  parameter int unsigned NUM_SEG  = NUM_SEG_DEF,
  parameter int unsigned TS_W     = TS_W_DEF,
  localparam int unsigned OFF_W   = $clog2(SEG_LEN),
  localparam int unsigned SEG_W   = $clog2(NUM_SEG),
  localparam int unsigned DEPTH   = NUM_SEG * SEG_LEN
) (
  input  logic                clk_i,
  input  logic                sample_we_i,
  input  logic [SEG_W-1:0]    wr_seg_i,
  input  logic [OFF_W-1:0]    wr_off_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic                ts_we_i,
  input  logic [TS_W-1:0]     ts_i,
  input  logic [SEG_W-1:0]    rd_seg_i,
  input  logic [OFF_W-1:0]    rd_off_i,
  output logic [SAMPLE_W-1:0] rd_sample_o,
  output logic [TS_W-1:0]     rd_ts_o
);
  logic [SAMPLE_W-1:0] sample_mem [DEPTH];
  logic [TS_W-1:0]     ts_mem     [NUM_SEG];

  always_ff @(posedge clk_i) begin
    if (sample_we_i) sample_mem[{wr_seg_i, wr_off_i}] <= sample_i;
    if (ts_we_i)     ts_mem[wr_seg_i]                 <= ts_i;
  end

  assign rd_sample_o = sample_mem[{rd_seg_i, rd_off_i}];
  assign rd_ts_o     = ts_mem[rd_seg_i];
endmodule

// File: rtl/segbuf_reader.sv
module segbuf_reader
  import segbuf_pkg::*;
#(
  parameter int unsigned SEG_LEN = SEG_LEN_DEF,
  localparam int unsigned BEAT_W = $clog2(SEG_LEN + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              avail_i,
  input  logic              ready_i,
  input  logic              skip_i,
  output logic [BEAT_W-1:0] beat_o,
  output logic              last_o,
  output logic              pop_o
);
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(SEG_LEN);

  assign last_o = avail_i && (beat_o == LAST_BEAT);
  assign pop_o  = avail_i && (skip_i || (ready_i && last_o));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      beat_o <= '0;
    end else if (pop_o) begin
      beat_o <= '0;
    end else if (avail_i && ready_i) begin
      beat_o <= beat_o + 1'b1;
    end
  end

  assert_beat_in_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_o <= LAST_BEAT);

  assert_skip_rewinds_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (avail_i && skip_i) |=> (beat_o == '0));
endmodule

// File: rtl/seg_trig_buffer.sv
module seg_trig_buffer
  import segbuf_pkg::*;
#(
  parameter int unsigned SAMPLE_W = SAMPLE_W_DEF,
  parameter int unsigned SEG_LEN  = SEG_LEN_DEF,
  parameter int unsigned NUM_SEG  = NUM_SEG_DEF,
  parameter int unsigned TS_W     = TS_W_DEF,
  parameter int unsigned OVF_W    = OVF_W_DEF
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic                sample_valid_i,
  input  logic [SAMPLE_W-1:0] threshold_i,
  output logic [TS_W-1:0]     rd_data_o,
  output logic                rd_valid_o,
  input  logic                rd_ready_i,
  output logic                rd_last_o,
  input  logic                rd_skip_i,
  output logic                data_avail_o,
  output logic [OVF_W-1:0]    ovf_cnt_o
);
  localparam int unsigned OFF_W  = $clog2(SEG_LEN);
  localparam int unsigned SEG_W  = $clog2(NUM_SEG);
  localparam int unsigned BEAT_W = $clog2(SEG_LEN + 1);

  logic                wr_en, commit, ts_we, full, empty, pop;
  logic [OFF_W-1:0]    wr_off, rd_off;
  logic [TS_W-1:0]     ts_cur, rd_ts;
  logic [SEG_W-1:0]    wr_seg, rd_seg;
  logic [BEAT_W-1:0]   beat;
  logic [SAMPLE_W-1:0] rd_sample;

  segbuf_capture #(
    .SAMPLE_W(SAMPLE_W), .SEG_LEN(SEG_LEN), .TS_W(TS_W), .OVF_W(OVF_W)
  ) u_capture (
    .clk_i, .rst_ni, .sample_i, .sample_valid_i, .threshold_i,
    .full_i   (full),
    .wr_en_o  (wr_en),
    .wr_off_o (wr_off),
    .commit_o (commit),
    .ts_we_o  (ts_we),
    .ts_o     (ts_cur),
    .ovf_cnt_o
  );

  segbuf_ring #(.NUM_SEG(NUM_SEG)) u_ring (
    .clk_i, .rst_ni,
    .commit_i (commit),
    .pop_i    (pop),
    .wr_seg_o (wr_seg),
    .rd_seg_o (rd_seg),
    .empty_o  (empty),
    .full_o   (full)
  );

  segbuf_store #(
    .SAMPLE_W(SAMPLE_W), .SEG_LEN(SEG_LEN), .NUM_SEG(NUM_SEG), .TS_W(TS_W)
  ) u_store (
    .clk_i,
    .sample_we_i (wr_en),
    .wr_seg_i    (wr_seg),
    .wr_off_i    (wr_off),
    .sample_i,
    .ts_we_i     (ts_we),
    .ts_i        (ts_cur),
    .rd_seg_i    (rd_seg),
    .rd_off_i    (rd_off),
    .rd_sample_o (rd_sample),
    .rd_ts_o     (rd_ts)
  );

  segbuf_reader #(.SEG_LEN(SEG_LEN)) u_reader (
    .clk_i, .rst_ni,
    .avail_i (!empty),
    .ready_i (rd_ready_i),
    .skip_i  (rd_skip_i),
    .beat_o  (beat),
    .last_o  (rd_last_o),
    .pop_o   (pop)
  );

  // beat 0 is the timestamp, beat n is sample n-1
  assign rd_off       = OFF_W'(beat - 1'b1);
  assign rd_valid_o   = !empty;
  assign data_avail_o = !empty;
  assign rd_data_o    = (beat == '0) ? rd_ts
                                     : {{(TS_W - SAMPLE_W){1'b0}}, rd_sample};

  assert_hold_when_stalled_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_o && !rd_ready_i && !rd_skip_i) |=>
      (rd_valid_o && $stable(rd_data_o) && $stable(rd_last_o)));

  assert_last_needs_valid_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_last_o |-> rd_valid_o);

  assert_first_beat_after_pop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_o && rd_ready_i && rd_last_o) |=> !rd_last_o);
endmodule

// File: tb/seg_trig_buffer_bench.sv
module seg_trig_buffer_bench;
  localparam int unsigned THR = 1000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] sample = '0;
  logic        sample_valid = 1'b0;
  logic [11:0] threshold = 12'(THR);
  logic [31:0] rd_data;
  logic        rd_valid, rd_last, data_avail;
  logic        rd_ready = 1'b0;
  logic        rd_skip = 1'b0;
  logic [7:0]  ovf_cnt;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [31:0] cyc;
  logic [32:0] exp_q[$];

  always #10 clk = ~clk;

  seg_trig_buffer u_seg_trig_buffer (
    .clk_i(clk), .rst_ni(rst_n), .sample_i(sample), .sample_valid_i(sample_valid),
    .threshold_i(threshold), .rd_data_o(rd_data), .rd_valid_o(rd_valid),
    .rd_ready_i(rd_ready), .rd_last_o(rd_last), .rd_skip_i(rd_skip),
    .data_avail_o(data_avail), .ovf_cnt_o(ovf_cnt)
  );

  // reference cycle count, zero in the first cycle after reset (R5)
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc <= '0;
    else        cyc <= cyc + 1;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // monitor: sample well after the edge, before the next one
  always begin
    @(posedge clk);
    #15;
    if (rst_n && rd_valid && rd_ready && !rd_skip) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R7 unexpected beat", rd_data, 32'h0);
      end else begin
        logic [32:0] e;
        e = exp_q.pop_front();
        chk(rd_data == e[31:0], "R3 R4 R5 R7 data", rd_data, e[31:0]);
        chk(rd_last == e[32], "R4 last", 32'(rd_last), 32'(e[32]));
      end
    end
  end

  task automatic idle_cycles(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sample_valid = 1'b0;
    end
  endtask

  // one complete capture; optional invalid gaps; samples above threshold inside
  task automatic send_seg(input int base, input bit gaps);
    @(negedge clk);
    sample       = 12'(THR + 1 + (base & 'h3ff));
    sample_valid = 1'b1;
    exp_q.push_back({1'b0, cyc});
    exp_q.push_back({1'b0, 20'h0, sample});
    for (int i = 1; i < 32; i++) begin
      if (gaps && (i % 5 == 0)) begin
        @(negedge clk);
        sample       = 12'hfff;
        sample_valid = 1'b0;
      end
      @(negedge clk);
      sample       = 12'((base + i * 37 + 1500) & 'hfff);
      sample_valid = 1'b1;
      exp_q.push_back({(i == 31), 20'h0, sample});
    end
    @(negedge clk);
    sample_valid = 1'b0;
    sample       = '0;
  endtask

  task automatic drain(input string req);
    rd_ready = 1'b1;
    for (int i = 0; i < 20000 && exp_q.size() != 0; i++) @(negedge clk);
    @(negedge clk);
    chk(exp_q.size() == 0, req, 32'(exp_q.size()), 32'h0);
    chk(data_avail == 1'b0, {req, " avail after drain"}, 32'(data_avail), 32'h0);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      done = 1'b1;
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(data_avail == 1'b0, "R1 avail", 32'(data_avail), 32'h0);
    chk(rd_valid == 1'b0, "R1 valid", 32'(rd_valid), 32'h0);
    chk(rd_last == 1'b0, "R1 last", 32'(rd_last), 32'h0);
    chk(ovf_cnt == 8'h0, "R1 ovf", 32'(ovf_cnt), 32'h0);

    // R2: samples at or below threshold never start a capture
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      sample       = (i % 2 == 0) ? 12'(THR) : 12'(THR - 300);
      sample_valid = 1'b1;
    end
    idle_cycles(3);
    chk(data_avail == 1'b0, "R2 no trigger at threshold", 32'(data_avail), 32'h0);

    // R3 R6 R8 R11: two segments with ready low, second watched mid-capture
    send_seg(10, 1'b1);
    chk(data_avail == 1'b1, "R8 avail after commit", 32'(data_avail), 32'h1);
    held = rd_data;
    chk(held == exp_q[0][31:0], "R5 head timestamp", held, exp_q[0][31:0]);
    idle_cycles(5);
    chk(rd_data == held && rd_valid, "R11 hold while stalled", rd_data, held);
    send_seg(200, 1'b0);
    idle_cycles(2);

    // R7: drain while another capture runs
    rd_ready = 1'b1;
    send_seg(333, 1'b1);
    drain("R7 concurrent drain");

    // R8: segment in progress does not raise the flag
    @(negedge clk);
    sample = 12'(THR + 50); sample_valid = 1'b1;
    exp_q.push_back({1'b0, cyc});
    exp_q.push_back({1'b0, 20'h0, sample});
    for (int i = 1; i < 20; i++) begin
      @(negedge clk);
      sample = 12'(i);
      exp_q.push_back({1'b0, 20'h0, sample});
    end
    @(negedge clk);
    sample_valid = 1'b0;
    chk(data_avail == 1'b0, "R8 partial segment hidden", 32'(data_avail), 32'h0);
    for (int i = 20; i < 32; i++) begin
      @(negedge clk);
      sample = 12'(i); sample_valid = 1'b1;
      exp_q.push_back({(i == 31), 20'h0, sample});
    end
    @(negedge clk);
    sample_valid = 1'b0;
    drain("R8 completed segment");

    // R9: skip the head segment
    rd_ready = 1'b0;
    send_seg(500, 1'b0);
    send_seg(777, 1'b1);
    @(negedge clk);
    rd_skip = 1'b1;
    @(negedge clk);
    rd_skip = 1'b0;
    for (int i = 0; i < 33; i++) void'(exp_q.pop_front());
    chk(rd_data == exp_q[0][31:0], "R9 next head after skip", rd_data, exp_q[0][31:0]);
    drain("R9 remaining segment");

    // R10: fill all 128 segments, then overflow
    rd_ready = 1'b0;
    for (int s = 0; s < 128; s++) send_seg(s * 7, 1'b0);
    chk(data_avail == 1'b1, "R10 full ring avail", 32'(data_avail), 32'h1);
    chk(ovf_cnt == 8'h0, "R10 no drop yet", 32'(ovf_cnt), 32'h0);
    @(negedge clk);
    sample = 12'(THR + 9); sample_valid = 1'b1;
    @(negedge clk);
    sample = 12'(THR - 1);
    idle_cycles(2);
    chk(ovf_cnt == 8'h1, "R10 drop counted", 32'(ovf_cnt), 32'h1);
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      sample = 12'(THR + 2); sample_valid = 1'b1;
    end
    idle_cycles(2);
    chk(ovf_cnt == 8'hff, "R10 saturation", 32'(ovf_cnt), 32'hff);
    drain("R10 all held segments");

    // R7 after pointer wrap
    send_seg(42, 1'b1);
    drain("R7 wrapped ring");

    done = 1'b1;
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule